// File: doc/BRIEF.md
# Power Management Capability Register Pair

This block provides the two configuration-space dwords of a PCI power-management capability. One is a read-only header that identifies the capability, marks the end of the capability list and gives the capability version. The other is a control/status dword. It holds the current device power state, an enable for the wake signal, and a sticky wake-event status bit. A simple configuration port reaches both dwords. The port has a dword address, per-byte write enables, write data, and read data that is decoded combinationally from the address.

An internal wake pulse from elsewhere in the chip always latches the status bit. The active-low wake output `pme_n_o` goes low only while the status bit and the enable bit are both set. Writing a one to the status bit clears it and releases the output. The 2-bit power state is driven to the rest of the chip. Its value out of reset comes from a mode strap sampled during reset.

Both stored items are small named state machines:
- Power state: states `PS_D0`, `PS_D1`, `PS_D2` and `PS_D3`. A lane-0 write to the control dword moves the machine to the state given by the written code, from any state.
- Wake status: states `WK_IDLE` and `WK_PENDING`. A wake pulse takes `WK_IDLE` to `WK_PENDING`. A write-one-to-clear with no wake pulse in the same cycle takes `WK_PENDING` back to `WK_IDLE`.

Top module: `pwr_mgmt_cap`

## Requirements
- R1: A read at dword address 14h (byte 50h) returns 0001_0001h: ID 01h in bits 7:0, list pointer 00h in bits 15:8, version 1 in bits 18:16. Writes to this address change nothing.
- R2: A read at dword address 15h (byte 54h) returns power state in bits 1:0, wake enable in bit 8 and wake status in bit 15. All other bits read 0, and writes to them are ignored.
- R3: A read at any other dword address returns 0.
- R4: A wake pulse sets the status bit on the next clock edge, whatever the enable bit holds.
- R5: A write to the control dword with byte lane 1 enabled and bit 15 set clears the status bit. With bit 15 clear, the status bit is unchanged.
- R6: When a wake pulse and a clearing write happen in the same cycle, the status bit stays set.
- R7: The enable bit (bit 8) is read/write and resets to 0. `pme_n_o` is low exactly when status and enable are both 1.
- R8: The power state (bits 1:0) is read/write, with codes 00=D0, 01=D1, 10=D2, 11=D3. It is presented on `pwr_state_o`.
- R9: Out of reset, the power state is D3 if `strap_i` was low during reset and D0 otherwise. Changes on `strap_i` after reset have no effect.
- R10: The power state is written only when byte lane 0 is enabled. The enable and status bits are written only when byte lane 1 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 1 | Mode strap, sampled while reset is low |
| cfg_addr | input | 6 | Dword address within configuration space |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| wake_i | input | 1 | Single-cycle wake event |
| pme_n_o | output | 1 | Active-low wake request |
| pwr_state_o | output | 2 | Current power state code |

## Verification
The bench sweeps every combination of byte enables, state code, enable value and clear bit, with wake pulses mixed in. The written data always has ones in the reserved bits. A design that ignored lane gating or leaked reserved bits would show a wrong read-back. The same-cycle wake-and-clear collision is aimed at directly, because a design that gave the clear priority would lose a wake event. Reset is applied with each strap level and the strap is toggled afterwards. A design that kept following the pin would change power state outside reset. All 64 addresses are read, which catches decode aliasing.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam logic [ADDR_W-1:0] HDR_DW_ADDR = 6'h14;
    localparam logic [ADDR_W-1:0] CSR_DW_ADDR = 6'h15;
    localparam logic [7:0] CAP_ID    = 8'h01;
    localparam logic [7:0] CAP_NEXT  = 8'h00;
    localparam logic [2:0] CAP_VER   = 3'h1;
    localparam int STATE_LSB = 0;
    localparam int EN_BIT    = 8;
    localparam int STS_BIT   = 15;

    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    typedef enum logic {
        WK_IDLE    = 1'b0,
        WK_PENDING = 1'b1
    } wk_state_e;
endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pm_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_i,
    input  logic       ld_i,
    input  logic [1:0] code_i,
    output logic [1:0] state_o
);
    pstate_e cur_q, nxt;

    // state register: strap picks the reset state while rst_n is low
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= strap_i ? PS_D0 : PS_D3;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        if (ld_i) begin
            unique case (code_i)
                2'b00: nxt = PS_D0;
                2'b01: nxt = PS_D1;
                2'b10: nxt = PS_D2;
                2'b11: nxt = PS_D3;
            endcase
        end
    end

    // output process
    always_comb begin
        unique case (cur_q)
            PS_D0: state_o = 2'b00;
            PS_D1: state_o = 2'b01;
            PS_D2: state_o = 2'b10;
            PS_D3: state_o = 2'b11;
        endcase
    end
endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
    import pm_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic lane_wr_i,
    input  logic en_wd_i,
    input  logic clr_wd_i,
    output logic sts_o,
    output logic en_o,
    output logic pme_n_o
);
    wk_state_e cur_q, nxt;
    logic      en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= WK_IDLE;
            en_q  <= 1'b0;
        end else begin
            cur_q <= nxt;
            if (lane_wr_i) en_q <= en_wd_i;
        end
    end

    // wake has priority over a same-cycle clear
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            WK_IDLE:    if (wake_i) nxt = WK_PENDING;
            WK_PENDING: if (lane_wr_i && clr_wd_i && !wake_i) nxt = WK_IDLE;
        endcase
    end

    always_comb begin
        unique case (cur_q)
            WK_IDLE:    begin sts_o = 1'b0; pme_n_o = 1'b1;  end
            WK_PENDING: begin sts_o = 1'b1; pme_n_o = !en_q; end
        endcase
        en_o = en_q;
    end
endmodule

// File: rtl/pm_cfg_rmux.sv
module pm_cfg_rmux
    import pm_cap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        state_i,
    input  logic              en_i,
    input  logic              sts_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] hdr_word, csr_word;

    always_comb begin
        hdr_word = '0;
        hdr_word[7:0]   = CAP_ID;
        hdr_word[15:8]  = CAP_NEXT;
        hdr_word[18:16] = CAP_VER;
        csr_word = '0;
        csr_word[STATE_LSB+1:STATE_LSB] = state_i;
        csr_word[EN_BIT]  = en_i;
        csr_word[STS_BIT] = sts_i;
        if (addr_i == HDR_DW_ADDR)      rdata_o = hdr_word;
        else if (addr_i == CSR_DW_ADDR) rdata_o = csr_word;
        else                            rdata_o = '0;
    end
endmodule

// File: rtl/pwr_mgmt_cap.sv
module pwr_mgmt_cap
    import pm_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              wake_i,
    output logic              pme_n_o,
    output logic [1:0]        pwr_state_o
);
    logic csr_wr, lane0_wr, lane1_wr;
    logic pme_sts, pme_en;

    assign csr_wr   = cfg_wr_en && (cfg_addr == CSR_DW_ADDR);
    assign lane0_wr = csr_wr && cfg_be[0];
    assign lane1_wr = csr_wr && cfg_be[1];

    logic unused_bits;
    assign unused_bits = ^{cfg_wdata[DATA_W-1:16], cfg_wdata[14:9],
                           cfg_wdata[7:2], cfg_be[BE_W-1:2]};

    pm_state_fsm u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .ld_i    (lane0_wr),
        .code_i  (cfg_wdata[STATE_LSB+1:STATE_LSB]),
        .state_o (pwr_state_o)
    );

    pm_wake_ctl u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_i    (wake_i),
        .lane_wr_i (lane1_wr),
        .en_wd_i   (cfg_wdata[EN_BIT]),
        .clr_wd_i  (cfg_wdata[STS_BIT]),
        .sts_o     (pme_sts),
        .en_o      (pme_en),
        .pme_n_o   (pme_n_o)
    );

    pm_cfg_rmux u_rmux (
        .addr_i  (cfg_addr),
        .state_i (pwr_state_o),
        .en_i    (pme_en),
        .sts_i   (pme_sts),
        .rdata_o (cfg_rdata)
    );
endmodule

// File: rtl/pm_cap_chk.sv
module pm_cap_chk
    import pm_cap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              strap_i,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr_en,
    input logic [BE_W-1:0]   cfg_be,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              wake_i,
    input logic              pme_n_o,
    input logic [1:0]        pwr_state_o,
    input logic              sts,
    input logic              en
);
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    logic csr_w;
    assign csr_w = cfg_wr_en && (cfg_addr == CSR_DW_ADDR);

    p_hdr_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == HDR_DW_ADDR) |-> (cfg_rdata == 32'h0001_0001));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == CSR_DW_ADDR) |-> ((cfg_rdata & 32'hFFFF_7EFC) == 32'h0));

    p_other_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != CSR_DW_ADDR && cfg_addr != HDR_DW_ADDR) |-> (cfg_rdata == 32'h0));

    p_wake_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> sts);

    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_w && cfg_be[1] && cfg_wdata[15] && !wake_i) |=> !sts);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !(csr_w && cfg_be[1] && cfg_wdata[15])) |=> sts);

    p_pme_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !sts) |-> pme_n_o);

    p_reset_state_r9: assert property (@(posedge clk)
        (started && rst_n && !$past(rst_n)) |->
        (pwr_state_o == ($past(strap_i) ? 2'b00 : 2'b11)));

    p_state_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_w && cfg_be[0]) |=> $stable(pwr_state_o));
endmodule

bind pwr_mgmt_cap pm_cap_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap_i),
    .cfg_addr    (cfg_addr),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .wake_i      (wake_i),
    .pme_n_o     (pme_n_o),
    .pwr_state_o (pwr_state_o),
    .sts         (pme_sts),
    .en          (pme_en)
);

// File: tb/pwr_mgmt_cap_tb.sv
module pwr_mgmt_cap_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_i = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wake_i = 1'b0;
    logic        pme_n_o;
    logic [1:0]  pwr_state_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_state;
    logic       m_en, m_sts;

    localparam logic [5:0] HDR = 6'h14;
    localparam logic [5:0] CSR = 6'h15;

    always #2.5 clk = ~clk;

    pwr_mgmt_cap u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cfg_addr(cfg_addr),
        .cfg_wr_en(cfg_wr_en), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wake_i(wake_i), .pme_n_o(pme_n_o),
        .pwr_state_o(pwr_state_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, returns at the following falling edge
    task automatic cyc(input logic wr, input logic [5:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic wk);
        cfg_wr_en = wr; cfg_addr = a; cfg_be = be; cfg_wdata = d; wake_i = wk;
        if (wr && a == CSR) begin
            if (be[0]) m_state = d[1:0];
            if (be[1]) begin
                m_en = d[8];
                if (d[15]) m_sts = 1'b0;
            end
        end
        if (wk) m_sts = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0; wake_i = 1'b0; cfg_addr = CSR;
        #0.5;
    endtask

    function automatic logic [31:0] csr_exp();
        return {16'h0, m_sts, 6'h0, m_en, 6'h0, m_state};
    endfunction

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap_i = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_state = s ? 2'b00 : 2'b11; m_en = 1'b0; m_sts = 1'b0;
        cfg_addr = CSR;
        #0.5;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: strap low -> D3
        do_reset(1'b0);
        chk("R9 reset strap low", {30'h0, pwr_state_o}, 32'h3);
        chk("R7 reset enable/pme", {31'h0, pme_n_o}, 32'h1);
        chk("R2 reset csr", cfg_rdata, 32'h0000_0003);
        strap_i = 1'b1;
        repeat (4) @(negedge clk);
        #0.5;
        chk("R9 strap ignored after reset", {30'h0, pwr_state_o}, 32'h3);
        do_reset(1'b1);
        chk("R9 reset strap high", {30'h0, pwr_state_o}, 32'h0);
        strap_i = 1'b0;
        repeat (2) @(negedge clk);
        #0.5;
        chk("R9 strap ignored after reset", {30'h0, pwr_state_o}, 32'h0);

        // R1 / R3: address sweep
        for (int a = 0; a < 64; a++) begin
            cfg_addr = a[5:0];
            #0.5;
            if (a == 6'h14)      chk("R1 header", cfg_rdata, 32'h0001_0001);
            else if (a == 6'h15) chk("R2 csr read", cfg_rdata, csr_exp());
            else                 chk("R3 unmapped zero", cfg_rdata, 32'h0);
        end
        cyc(1'b1, HDR, 4'hF, 32'hFFFF_FFFF, 1'b0);
        cfg_addr = HDR; #0.5;
        chk("R1 header write ignored", cfg_rdata, 32'h0001_0001);

        // R4: wake with enable off
        cyc(1'b0, CSR, 4'h0, 32'h0, 1'b1);
        chk("R4 status set enable off", cfg_rdata, csr_exp());
        chk("R7 pme high enable off", {31'h0, pme_n_o}, 32'h1);
        // R7: enable -> pme low
        cyc(1'b1, CSR, 4'h2, 32'h0000_0100, 1'b0);
        chk("R7 pme low", {31'h0, pme_n_o}, 32'h0);
        // R5: write zero to status no effect
        cyc(1'b1, CSR, 4'h2, 32'h0000_0100, 1'b0);
        chk("R5 write zero keeps status", cfg_rdata, 32'h0000_8100);
        // R6: collision
        cyc(1'b1, CSR, 4'h2, 32'h0000_8100, 1'b1);
        chk("R6 wake wins", cfg_rdata, 32'h0000_8100);
        // R10: clear with lane1 disabled
        cyc(1'b1, CSR, 4'hD, 32'h0000_8100, 1'b0);
        chk("R10 lane1 off no clear", cfg_rdata, csr_exp());
        // R5: clear
        cyc(1'b1, CSR, 4'h2, 32'h0000_8100, 1'b0);
        chk("R5 clear", cfg_rdata, 32'h0000_0100);
        chk("R5 pme released", {31'h0, pme_n_o}, 32'h1);

        // R8 / R10 / R2: exhaustive sweep
        for (int i = 0; i < 512; i++) begin
            logic [3:0]  be;
            logic [31:0] d;
            be = i[3:0];
            d  = {16'hFFFF, i[7], 6'h3F, i[6], 6'h3F, i[5:4]};
            cyc(1'b1, CSR, be, d, i[8] ^ (i % 3 == 0));
            chk("R10 csr after write", cfg_rdata, csr_exp());
            chk("R8 state output", {30'h0, pwr_state_o}, {30'h0, m_state});
            chk("R7 pme output", {31'h0, pme_n_o}, {31'h0, !(m_sts && m_en)});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule